// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the status and control flags of an asynchronous serial port that carries an extra address/data marker bit in each frame. A host reaches the flags through a plain register port made of a read strobe, a write strobe, write data and read data. The receiver and the transmitter report their events through single-cycle pulses. The block answers with the flag values, with a pulse that tells the receive data holder to take the byte, with a pulse that marks the receive data as valid, and with a stall level that holds off further reception.

Two flags are sticky: the receive parity error and the transmit data-empty status. Software cannot clear either flag with a blind write. A write of 0 clears such a flag only when the last read of the register returned that flag as 1. While a parity error is pending, the receiver is held off. The transmit-end flag follows the data-empty status when the last bit of a character leaves the line. A transmitter that is switched off forces the transmit-end flag high.

Top module: `sp_status_flags`

## Requirements
- R1: After reset, `perr_flag`=0, `tend_flag`=1, `tdre_flag`=1, `mp_rx_flag`=0 and `mp_tx_flag`=0. `bus_rdata` places the flags as follows: bit 0 is the transmit marker, bit 1 the received marker, bit 2 transmit-end, bit 3 parity error and bit 4 data-empty. All other bits read 0.
- R2: A frame is accepted when `rx_frame_done` is 1, `rx_en` is 1 and `perr_flag` is 0. An accepted frame always pulses `rx_dreg_load` in the same cycle. It pulses `rx_full_set` only if `rx_parity_bad` is 0. If `rx_parity_bad` is 1, `perr_flag` is 1 from the next cycle.
- R3: While `perr_flag` is 1, `rx_stall` is 1 and incoming frames are ignored: there is no load pulse, no full pulse, and `mp_rx_flag` is unchanged.
- R4: A write with bit 3 at 0 clears `perr_flag` only if the most recent earlier register access was a read that returned bit 3 as 1. Writing 1, writing without such a read, or a second write after that read leaves the flag unchanged.
- R5: While `rx_en` is 0, `perr_flag` and `mp_rx_flag` keep their values, whatever frames or clearing writes arrive.
- R6: `mp_rx_flag` takes `rx_mp_bit` of every accepted frame. `mp_tx_flag` takes bit 0 of every register write.
- R7: While `tx_en` is 0, `tend_flag` and `tdre_flag` are 1 from the next cycle, whatever other events arrive.
- R8: `tx_last_bit` sets `tend_flag` when `tdre_flag` is 1 and has no effect when `tdre_flag` is 0.
- R9: `tdre_flag` and `tend_flag` clear on a write with bit 4 at 0 that follows a read returning bit 4 as 1, and on `tx_dreg_dma_wr`. `tx_shift_load` sets `tdre_flag`.
- R10: When a set event and a clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Register read data |
| rx_en | input | 1 | Receiver enable |
| rx_frame_done | input | 1 | Receiver finished a frame |
| rx_parity_bad | input | 1 | Parity of that frame was wrong |
| rx_mp_bit | input | 1 | Marker bit of that frame |
| tx_en | input | 1 | Transmitter enable |
| tx_shift_load | input | 1 | Transmitter took the data byte |
| tx_last_bit | input | 1 | Last bit of a character sent |
| tx_dreg_dma_wr | input | 1 | Transfer agent wrote the transmit data register |
| rx_dreg_load | output | 1 | Load received byte into data holder |
| rx_full_set | output | 1 | Mark receive data valid |
| rx_stall | output | 1 | Hold off reception |
| perr_flag | output | 1 | Parity error flag |
| tend_flag | output | 1 | Transmit-end flag |
| tdre_flag | output | 1 | Transmit data-empty flag |
| mp_rx_flag | output | 1 | Received marker bit |
| mp_tx_flag | output | 1 | Marker bit for transmit |

## Verification
The bench builds the block with the default 8-bit data width and the default bit positions, so every flag sits in one byte that the bench composes arithmetically. For the parity clear, it sweeps all 16 combinations of read-before-write, written bit value, receiver enable, and an intervening write. For the transmit flags, it sweeps all 16 combinations of read-before-write, written bit value, a same-cycle shift load, and a same-cycle last-bit event. Together these sweeps cover each branch of the clearing rule and each set-versus-clear collision.

// File: rtl/sp_flags_pkg.sv
package sp_flags_pkg;
  localparam int unsigned DEF_DW      = 8;
  localparam int unsigned DEF_BIT_MPT = 0;
  localparam int unsigned DEF_BIT_MPR = 1;
  localparam int unsigned DEF_BIT_END = 2;
  localparam int unsigned DEF_BIT_PER = 3;
  localparam int unsigned DEF_BIT_EMP = 4;
  localparam int unsigned N_ARMED     = 2;
  localparam int unsigned ARM_PER     = 0;
  localparam int unsigned ARM_EMP     = 1;
endpackage

// File: rtl/sp_clr_arm.sv
module sp_clr_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic flag_val,
  input  logic wr_bit,
  output logic clr_req
);
  logic arm_q, arm_d;

  always_comb begin
    arm_d = arm_q;
    if (bus_rd)      arm_d = flag_val;
    else if (bus_wr) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  assign clr_req = bus_wr & arm_q & ~wr_bit;
endmodule

// File: rtl/sp_rx_flags.sv
module sp_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic frame_done,
  input  logic parity_bad,
  input  logic mp_bit,
  input  logic clr_req,
  output logic perr,
  output logic mp_rx,
  output logic dreg_load,
  output logic full_set
);
  logic perr_q, perr_d, mp_q, mp_d, accept;

  assign accept = rx_en & frame_done & ~perr_q;

  always_comb begin
    perr_d = perr_q;
    if (rx_en) begin
      if (accept && parity_bad) perr_d = 1'b1;
      else if (clr_req)         perr_d = 1'b0;
    end
    mp_d = accept ? mp_bit : mp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      mp_q   <= 1'b0;
    end else begin
      perr_q <= perr_d;
      mp_q   <= mp_d;
    end
  end

  assign perr      = perr_q;
  assign mp_rx     = mp_q;
  assign dreg_load = accept;
  assign full_set  = accept & ~parity_bad;
endmodule

// File: rtl/sp_tx_flags.sv
module sp_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic shift_load,
  input  logic last_bit,
  input  logic dma_wr,
  input  logic clr_req,
  input  logic bus_wr,
  input  logic mpt_bit,
  output logic tdre,
  output logic tend,
  output logic mp_tx
);
  logic tdre_q, tdre_d, tend_q, tend_d, mpt_q, mpt_d, clr_any;

  assign clr_any = clr_req | dma_wr;

  always_comb begin
    tdre_d = tdre_q;
    if (!tx_en || shift_load)       tdre_d = 1'b1;
    else if (clr_any)               tdre_d = 1'b0;
    tend_d = tend_q;
    if (!tx_en || (last_bit && tdre_q)) tend_d = 1'b1;
    else if (clr_any)                   tend_d = 1'b0;
    mpt_d = bus_wr ? mpt_bit : mpt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdre_q <= 1'b1;
      tend_q <= 1'b1;
      mpt_q  <= 1'b0;
    end else begin
      tdre_q <= tdre_d;
      tend_q <= tend_d;
      mpt_q  <= mpt_d;
    end
  end

  assign tdre  = tdre_q;
  assign tend  = tend_q;
  assign mp_tx = mpt_q;
endmodule

// File: rtl/sp_status_flags.sv
module sp_status_flags
  import sp_flags_pkg::*;
#(
  parameter int unsigned DW      = DEF_DW,
  parameter int unsigned BIT_MPT = DEF_BIT_MPT,
  parameter int unsigned BIT_MPR = DEF_BIT_MPR,
  parameter int unsigned BIT_END = DEF_BIT_END,
  parameter int unsigned BIT_PER = DEF_BIT_PER,
  parameter int unsigned BIT_EMP = DEF_BIT_EMP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_en,
  input  logic          rx_frame_done,
  input  logic          rx_parity_bad,
  input  logic          rx_mp_bit,
  input  logic          tx_en,
  input  logic          tx_shift_load,
  input  logic          tx_last_bit,
  input  logic          tx_dreg_dma_wr,
  output logic          rx_dreg_load,
  output logic          rx_full_set,
  output logic          rx_stall,
  output logic          perr_flag,
  output logic          tend_flag,
  output logic          tdre_flag,
  output logic          mp_rx_flag,
  output logic          mp_tx_flag
);
  localparam int unsigned ARM_POS [N_ARMED] = '{BIT_PER, BIT_EMP};

  logic [N_ARMED-1:0] arm_flag, arm_clr;
  logic               wdata_unused;

  assign wdata_unused         = ^bus_wdata;
  assign arm_flag[ARM_PER]    = perr_flag;
  assign arm_flag[ARM_EMP]    = tdre_flag;

  for (genvar g = 0; g < N_ARMED; g++) begin : g_arm
    sp_clr_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .flag_val (arm_flag[g]),
      .wr_bit   (bus_wdata[ARM_POS[g]]),
      .clr_req  (arm_clr[g])
    );
  end

  sp_rx_flags u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .frame_done (rx_frame_done),
    .parity_bad (rx_parity_bad),
    .mp_bit     (rx_mp_bit),
    .clr_req    (arm_clr[ARM_PER]),
    .perr       (perr_flag),
    .mp_rx      (mp_rx_flag),
    .dreg_load  (rx_dreg_load),
    .full_set   (rx_full_set)
  );

  sp_tx_flags u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .shift_load (tx_shift_load),
    .last_bit   (tx_last_bit),
    .dma_wr     (tx_dreg_dma_wr),
    .clr_req    (arm_clr[ARM_EMP]),
    .bus_wr     (bus_wr),
    .mpt_bit    (bus_wdata[BIT_MPT]),
    .tdre       (tdre_flag),
    .tend       (tend_flag),
    .mp_tx      (mp_tx_flag)
  );

  assign rx_stall = perr_flag;

  always_comb begin
    bus_rdata          = '0;
    bus_rdata[BIT_MPT] = mp_tx_flag;
    bus_rdata[BIT_MPR] = mp_rx_flag;
    bus_rdata[BIT_END] = tend_flag;
    bus_rdata[BIT_PER] = perr_flag;
    bus_rdata[BIT_EMP] = tdre_flag;
  end
endmodule

// File: rtl/sp_status_flags_chk.sv
module sp_status_flags_chk #(
  parameter int unsigned DW      = 8,
  parameter int unsigned BIT_PER = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic          rx_en,
  input logic          rx_frame_done,
  input logic          rx_parity_bad,
  input logic          tx_en,
  input logic          tx_last_bit,
  input logic          rx_dreg_load,
  input logic          rx_full_set,
  input logic          perr_flag,
  input logic          tend_flag,
  input logic          tdre_flag
);
  AST_PERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && rx_frame_done && rx_parity_bad && !perr_flag |=> perr_flag); // R2
  AST_PARITY_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_parity_bad |-> !rx_full_set); // R2
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    perr_flag |-> !rx_dreg_load && !rx_full_set); // R3
  AST_PERR_CLR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_flag) |-> $past(bus_wr) && !$past(bus_wdata[BIT_PER]) && $past(rx_en)); // R4
  AST_RX_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(perr_flag)); // R5
  AST_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tend_flag && tdre_flag); // R7
  AST_TEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && tx_last_bit && tdre_flag |=> tend_flag); // R8
endmodule

bind sp_status_flags sp_status_flags_chk #(.DW(DW), .BIT_PER(BIT_PER)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .rx_en         (rx_en),
  .rx_frame_done (rx_frame_done),
  .rx_parity_bad (rx_parity_bad),
  .tx_en         (tx_en),
  .tx_last_bit   (tx_last_bit),
  .rx_dreg_load  (rx_dreg_load),
  .rx_full_set   (rx_full_set),
  .perr_flag     (perr_flag),
  .tend_flag     (tend_flag),
  .tdre_flag     (tdre_flag)
);

// File: tb/sp_status_flags_bench.sv
module sp_status_flags_bench;
  localparam int DW = 8;
  localparam int B_MPT = 0, B_MPR = 1, B_END = 2, B_PER = 3, B_EMP = 4;

  logic clk, rst_n, bus_rd, bus_wr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic rx_en, rx_frame_done, rx_parity_bad, rx_mp_bit;
  logic tx_en, tx_shift_load, tx_last_bit, tx_dreg_dma_wr;
  logic rx_dreg_load, rx_full_set, rx_stall;
  logic perr_flag, tend_flag, tdre_flag, mp_rx_flag, mp_tx_flag;
  int n_chk, n_bad;

  sp_status_flags u_sp_status_flags (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    rx_frame_done = 0; rx_parity_bad = 0; rx_mp_bit = 0;
    tx_shift_load = 0; tx_last_bit = 0; tx_dreg_dma_wr = 0;
  endtask

  task automatic do_reset();
    idle(); rx_en = 1; tx_en = 1; rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic frame(logic bad, logic mp, int exp_load, int exp_full, string tag);
    rx_frame_done = 1; rx_parity_bad = bad; rx_mp_bit = mp;
    #1;
    chk({tag, " load"}, int'(rx_dreg_load), exp_load);
    chk({tag, " full"}, int'(rx_full_set), exp_full);
    tick(); idle();
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    do_reset();
    // R1 reset state and field layout
    chk("R1 perr", int'(perr_flag), 0);
    chk("R1 tend", int'(tend_flag), 1);
    chk("R1 tdre", int'(tdre_flag), 1);
    chk("R1 mprx", int'(mp_rx_flag), 0);
    chk("R1 mptx", int'(mp_tx_flag), 0);
    chk("R1 rdata", int'(bus_rdata), (1 << B_END) | (1 << B_EMP));

    // R2 / R6 clean frame, then bad frame
    frame(0, 1, 1, 1, "R2 clean");
    chk("R6 mprx capture", int'(mp_rx_flag), 1);
    frame(1, 0, 1, 0, "R2 bad");
    chk("R2 perr set", int'(perr_flag), 1);
    chk("R6 mprx capture0", int'(mp_rx_flag), 0);
    chk("R3 stall", int'(rx_stall), 1);
    chk("R1 rdata perr", int'(bus_rdata), (1 << B_PER) | (1 << B_END) | (1 << B_EMP));
    // R3 stalled frame ignored
    frame(0, 1, 0, 0, "R3 blocked");
    chk("R3 mprx held", int'(mp_rx_flag), 0);

    // R4 / R5 sweep over read-first, written bit, rx_en, intervening write
    for (int v = 0; v < 16; v++) begin
      automatic bit a = v[0], b = v[1], c = v[2], d = v[3];
      automatic int cleared = (a && !b && c && !d) ? 1 : 0;
      do_reset();
      frame(1, 0, 1, 0, "R2 setup");
      if (a) begin bus_rd = 1; tick(); idle(); end
      if (d) begin bus_wr = 1; bus_wdata = DW'(1 << B_PER); tick(); idle(); end
      bus_wr = 1; bus_wdata = DW'(int'(b) << B_PER); rx_en = c;
      tick(); idle(); rx_en = 1;
      chk(c ? "R4 perr sweep" : "R5 perr frozen", int'(perr_flag), 1 - cleared);
    end

    // R5 receiver off: frames ignored, marker held
    do_reset();
    rx_en = 0;
    frame(1, 1, 0, 0, "R5 off");
    chk("R5 mprx held", int'(mp_rx_flag), 0);
    chk("R5 perr held", int'(perr_flag), 0);
    rx_en = 1;

    // R6 transmit marker follows writes
    bus_wr = 1; bus_wdata = DW'(1 << B_MPT); tick(); idle();
    chk("R6 mptx 1", int'(mp_tx_flag), 1);
    chk("R6 rdata mptx", int'(bus_rdata[B_MPT]), 1);
    bus_wr = 1; bus_wdata = '0; tick(); idle();
    chk("R6 mptx 0", int'(mp_tx_flag), 0);

    // R9 / R10 sweep over read-first, written bit, shift load, last bit
    for (int v = 0; v < 16; v++) begin
      automatic bit a = v[0], b = v[1], c = v[2], d = v[3];
      automatic int clr = (a && !b) ? 1 : 0;
      do_reset();
      if (a) begin bus_rd = 1; tick(); idle(); end
      bus_wr = 1; bus_wdata = DW'(int'(b) << B_EMP);
      tx_shift_load = c; tx_last_bit = d;
      tick(); idle();
      chk("R10 tdre sweep", int'(tdre_flag), (c || !clr) ? 1 : 0);
      chk("R9 tend sweep", int'(tend_flag), (d || !clr) ? 1 : 0);
    end

    // R9 transfer-agent write, R8 last bit gated by empty
    do_reset();
    tx_dreg_dma_wr = 1; tick(); idle();
    chk("R9 dma tdre", int'(tdre_flag), 0);
    chk("R9 dma tend", int'(tend_flag), 0);
    tx_last_bit = 1; tick(); idle();
    chk("R8 no set when full", int'(tend_flag), 0);
    tx_shift_load = 1; tick(); idle();
    chk("R9 load sets tdre", int'(tdre_flag), 1);
    chk("R8 tend still 0", int'(tend_flag), 0);
    tx_last_bit = 1; tick(); idle();
    chk("R8 tend set", int'(tend_flag), 1);

    // R7 transmitter off forces both, even against a dma write
    tx_dreg_dma_wr = 1; tick(); idle();
    chk("R9 dma again", int'(tend_flag), 0);
    tx_en = 0; tx_dreg_dma_wr = 1; tick(); idle();
    chk("R7 tend forced", int'(tend_flag), 1);
    chk("R7 tdre forced", int'(tdre_flag), 1);
    tx_en = 1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule